// File: doc/BRIEF.md
# Descriptor-Driven Storage DMA Engine

This block is the bus-master data mover of a storage channel. Software programs a descriptor table base address and a direction, then sets the start bit. The engine walks a table of 8-byte descriptors held in memory, each naming a buffer address and a byte count. It moves the buffer one 32-bit word at a time between a simple request/acknowledge memory port and a device-side word FIFO, and stops after the descriptor flagged as final.

Completion raises an interrupt flag and fault raises an error flag. Both flags are cleared by writing one. Two capability bits for the attached drives sit in the same status register. Clearing the start bit aborts a transfer at once.

The register file has three words at word addresses 0 (command), 1 (status) and 2 (table base). Reads are combinational and writes take effect at the next clock edge.

Top module: `bmdma_engine`

## Requirements
- R1: After reset the command, status and base registers read 0, `irq` is 0, and no memory request, FIFO pop or FIFO push is issued.
- R2: Writing the command register with bit 0 going from 0 to 1 starts processing at the base register's address and sets status bit 0 (active). Writing bit 0 as 1 while it is already 1 starts nothing.
- R3: Command bit 3 is sampled at start. When it is 1, words are popped from the device FIFO and written to memory. When it is 0, words are read from memory and pushed to the device FIFO. Order is preserved in both cases.
- R4: A descriptor is two words. The word at table+0 is the buffer address. The word at table+4 holds the byte count in bits 15:0 and the final flag in bit 31, and bits 30:16 are ignored. Descriptors are taken 8 bytes apart until the final one has been processed.
- R5: A descriptor moves ceil(count/4) words at ascending word addresses. A count of 0 moves 65536 bytes, which is 16384 words.
- R6: After the final descriptor's last word has moved, status reads active 0, error 0 and interrupt (bit 2) 1. `irq` equals the interrupt flag.
- R7: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves it unchanged. An event that sets a flag wins over a clear in the same cycle.
- R8: Status bits 5 and 6 read back exactly as last written. Bit 0 cannot be written, and all other status bits read 0.
- R9: The base register ignores written bits 1:0 and reads them as 0.
- R10: Writing command bit 0 as 0 clears active on the next edge. No further memory request, pop or push follows, and the interrupt flag is not set.
- R11: A memory acknowledge that carries `mem_err` sets the error flag, clears active, and stops all further requests without setting the interrupt flag.
- R12: While active is 0, `mem_req`, `dev_rd_pop` and `dev_wr_push` stay low.
- R13: Once raised, `mem_req` keeps its address and write enable until the cycle of `mem_ack`, unless the transfer is aborted. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address: 0 command, 1 status, 2 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completed request faulted |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_rd_valid | input | 1 | Device FIFO has a word for memory |
| dev_rd_data | input | 32 | Word from the device FIFO |
| dev_rd_pop | output | 1 | Take the word from the device FIFO |
| dev_wr_ready | input | 1 | Device FIFO can accept a word |
| dev_wr_data | output | 32 | Word for the device FIFO |
| dev_wr_push | output | 1 | Write dev_wr_data into the device FIFO |
| irq | output | 1 | Interrupt flag |

## Verification
Register reads are combinational. Register writes, completion flags, error flags and the active bit all change on the first edge after their cause: the write strobe, the final word's acknowledge or push, or a faulting acknowledge. The bench drives on falling edges and samples one falling edge later. For completion it polls active at each falling edge and checks the flags and data in the same half-cycle that active is seen low. Memory and FIFO counts are taken by models that update on the same edge as the engine. They are therefore final when the poll ends. Abort and fault quiet periods are watched for eight cycles from the falling edge after the triggering write or acknowledge.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int ADDR_W         = 32;
  localparam int DATA_W         = 32;
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int LEN_W          = 16;
  localparam int WCNT_W         = LEN_W - $clog2(BYTES_PER_WORD) + 1;
  localparam int DESC_STRIDE    = 2 * BYTES_PER_WORD;
  localparam int FINAL_BIT      = 31;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_BASE = 2'd2;

  localparam int CMD_RUN   = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP0   = 5;
  localparam int ST_CAP1   = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DADDR,
    S_DLEN,
    S_GET,
    S_PUT
  } seq_state_t;
endpackage

// File: rtl/bmdma_len_decode.sv
module bmdma_len_decode
  import bmdma_pkg::*;
#(
  parameter int LW  = LEN_W,
  parameter int BPW = BYTES_PER_WORD,
  parameter int WW  = WCNT_W
) (
  input  logic [LW-1:0] len_bytes,
  output logic [WW-1:0] len_words
);
  localparam int SH = $clog2(BPW);

  logic [LW:0] full_bytes;
  logic [LW:0] rounded;

  always_comb begin
    // a zero count stands for the full 2**LW byte range
    full_bytes = (len_bytes == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, len_bytes};
    rounded    = full_bytes + (LW+1)'(BPW - 1);
    len_words  = rounded[LW:SH];
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ev_done,
  input  logic          ev_fault,
  output logic          run,
  output logic          go,
  output logic          go_tomem,
  output logic [AW-1:0] base,
  output logic          active,
  output logic          err_flag,
  output logic          int_flag,
  output logic [1:0]    caps
);
  logic          run_q, run_d;
  logic          dir_q, dir_d;
  logic          act_q, act_d;
  logic          err_q, err_d;
  logic          int_q, int_d;
  logic [1:0]    cap_q, cap_d;
  logic [AW-3:0] base_q, base_d;
  logic          wr_cmd, wr_stat, wr_base, stop;

  always_comb begin
    wr_cmd   = wr_en && (wr_addr == RA_CMD);
    wr_stat  = wr_en && (wr_addr == RA_STAT);
    wr_base  = wr_en && (wr_addr == RA_BASE);
    go       = wr_cmd && wr_data[CMD_RUN] && !run_q;
    go_tomem = wr_data[CMD_TOMEM];
    stop     = wr_cmd && !wr_data[CMD_RUN];

    run_d  = wr_cmd ? wr_data[CMD_RUN] : run_q;
    dir_d  = wr_cmd ? wr_data[CMD_TOMEM] : dir_q;
    base_d = wr_base ? wr_data[AW-1:2] : base_q;
    cap_d  = wr_stat ? {wr_data[ST_CAP1], wr_data[ST_CAP0]} : cap_q;

    act_d = act_q;
    if (ev_done || ev_fault || stop) act_d = 1'b0;
    if (go)                          act_d = 1'b1;

    err_d = err_q;
    if (wr_stat && wr_data[ST_ERR]) err_d = 1'b0;
    if (ev_fault)                   err_d = 1'b1;

    int_d = int_q;
    if (wr_stat && wr_data[ST_INT]) int_d = 1'b0;
    if (ev_done)                    int_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      cap_q  <= '0;
      base_q <= '0;
    end else begin
      run_q  <= run_d;
      dir_q  <= dir_d;
      act_q  <= act_d;
      err_q  <= err_d;
      int_q  <= int_d;
      cap_q  <= cap_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CMD: begin
        rd_data[CMD_RUN]   = run_q;
        rd_data[CMD_TOMEM] = dir_q;
      end
      RA_STAT: begin
        rd_data[ST_ACT]  = act_q;
        rd_data[ST_ERR]  = err_q;
        rd_data[ST_INT]  = int_q;
        rd_data[ST_CAP0] = cap_q[0];
        rd_data[ST_CAP1] = cap_q[1];
      end
      RA_BASE: rd_data[AW-1:0] = {base_q, 2'b00};
      default: rd_data = '0;
    endcase
  end

  assign run      = run_q;
  assign base     = {base_q, 2'b00};
  assign active   = act_q;
  assign err_flag = err_q;
  assign int_flag = int_q;
  assign caps     = cap_q;
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
  import bmdma_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int LW  = LEN_W,
  parameter int BPW = BYTES_PER_WORD,
  parameter int WW  = WCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          go,
  input  logic          go_tomem,
  input  logic [AW-1:0] base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_rd_valid,
  input  logic [DW-1:0] dev_rd_data,
  output logic          dev_rd_pop,
  input  logic          dev_wr_ready,
  output logic [DW-1:0] dev_wr_data,
  output logic          dev_wr_push,
  output logic          ev_done,
  output logic          ev_fault
);
  localparam logic [AW-1:0] WSTEP = AW'(BPW);
  localparam logic [AW-1:0] DSTEP = AW'(2 * BPW);
  localparam int            SH    = $clog2(BPW);

  seq_state_t    state_q, state_d;
  logic [AW-1:0] tbl_q, tbl_d;
  logic [AW-1:0] buf_q, buf_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [WW-1:0] left_q, left_d;
  logic          last_q, last_d;
  logic          tomem_q, tomem_d;
  logic          step;
  logic [WW-1:0] dec_words;

  bmdma_len_decode #(.LW(LW), .BPW(BPW), .WW(WW)) u_len (
    .len_bytes (mem_rdata[LW-1:0]),
    .len_words (dec_words)
  );

  always_comb begin
    state_d     = state_q;
    tbl_d       = tbl_q;
    buf_d       = buf_q;
    dat_d       = dat_q;
    left_d      = left_q;
    last_d      = last_q;
    tomem_d     = tomem_q;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = tbl_q;
    mem_wdata   = dat_q;
    dev_rd_pop  = 1'b0;
    dev_wr_push = 1'b0;
    dev_wr_data = dat_q;
    ev_done     = 1'b0;
    ev_fault    = 1'b0;
    step        = 1'b0;

    case (state_q)
      S_DADDR: begin
        mem_req  = 1'b1;
        mem_addr = tbl_q;
        if (mem_ack) begin
          if (mem_err) ev_fault = 1'b1;
          else begin
            buf_d   = {mem_rdata[AW-1:SH], {SH{1'b0}}};
            state_d = S_DLEN;
          end
        end
      end
      S_DLEN: begin
        mem_req  = 1'b1;
        mem_addr = tbl_q + WSTEP;
        if (mem_ack) begin
          if (mem_err) ev_fault = 1'b1;
          else begin
            left_d  = dec_words;
            last_d  = mem_rdata[FINAL_BIT];
            tbl_d   = tbl_q + DSTEP;
            state_d = S_GET;
          end
        end
      end
      S_GET: begin
        if (tomem_q) begin
          dev_rd_pop = dev_rd_valid;
          if (dev_rd_valid) begin
            dat_d   = dev_rd_data;
            state_d = S_PUT;
          end
        end else begin
          mem_req  = 1'b1;
          mem_addr = buf_q;
          if (mem_ack) begin
            if (mem_err) ev_fault = 1'b1;
            else begin
              dat_d   = mem_rdata;
              state_d = S_PUT;
            end
          end
        end
      end
      S_PUT: begin
        if (tomem_q) begin
          mem_req  = 1'b1;
          mem_we   = 1'b1;
          mem_addr = buf_q;
          if (mem_ack) begin
            if (mem_err) ev_fault = 1'b1;
            else         step     = 1'b1;
          end
        end else begin
          dev_wr_push = dev_wr_ready;
          step        = dev_wr_ready;
        end
      end
      default: ;
    endcase

    if (step) begin
      buf_d  = buf_q + WSTEP;
      left_d = left_q - WW'(1);
      if (left_q == WW'(1)) begin
        if (last_q) begin
          ev_done = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_DADDR;
        end
      end else begin
        state_d = S_GET;
      end
    end

    if (ev_fault) state_d = S_IDLE;

    // abort: a cleared run bit silences the engine in the same cycle
    if (!run) begin
      mem_req     = 1'b0;
      mem_we      = 1'b0;
      dev_rd_pop  = 1'b0;
      dev_wr_push = 1'b0;
      ev_done     = 1'b0;
      ev_fault    = 1'b0;
      state_d     = S_IDLE;
    end

    if (go) begin
      state_d = S_DADDR;
      tbl_d   = base;
      tomem_d = go_tomem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tbl_q   <= '0;
      buf_q   <= '0;
      dat_q   <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      tomem_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tbl_q   <= tbl_d;
      buf_q   <= buf_d;
      dat_q   <= dat_d;
      left_q  <= left_d;
      last_q  <= last_d;
      tomem_q <= tomem_d;
    end
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        dev_rd_valid,
  input  logic [31:0] dev_rd_data,
  output logic        dev_rd_pop,
  input  logic        dev_wr_ready,
  output logic [31:0] dev_wr_data,
  output logic        dev_wr_push,
  output logic        irq
);
  logic              cmd_run;
  logic              go;
  logic              go_tomem;
  logic [ADDR_W-1:0] base;
  logic              st_active;
  logic              st_err;
  logic              st_int;
  logic [1:0]        st_caps;
  logic              ev_done;
  logic              ev_fault;

  bmdma_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .rd_addr  (reg_addr),
    .rd_data  (reg_rdata),
    .ev_done  (ev_done),
    .ev_fault (ev_fault),
    .run      (cmd_run),
    .go       (go),
    .go_tomem (go_tomem),
    .base     (base),
    .active   (st_active),
    .err_flag (st_err),
    .int_flag (st_int),
    .caps     (st_caps)
  );

  bmdma_seq #(
    .AW(ADDR_W), .DW(DATA_W), .LW(LEN_W), .BPW(BYTES_PER_WORD), .WW(WCNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (cmd_run),
    .go           (go),
    .go_tomem     (go_tomem),
    .base         (base),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_err      (mem_err),
    .mem_rdata    (mem_rdata),
    .dev_rd_valid (dev_rd_valid),
    .dev_rd_data  (dev_rd_data),
    .dev_rd_pop   (dev_rd_pop),
    .dev_wr_ready (dev_wr_ready),
    .dev_wr_data  (dev_wr_data),
    .dev_wr_push  (dev_wr_push),
    .ev_done      (ev_done),
    .ev_fault     (ev_fault)
  );

  assign irq = st_int;
endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk
  import bmdma_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        dev_rd_pop,
  input logic        dev_wr_push,
  input logic        cmd_run,
  input logic        st_active,
  input logic        st_err,
  input logic        st_int,
  input logic [1:0]  st_caps,
  input logic        ev_done,
  input logic        ev_fault
);
  logic stat_wr;
  assign stat_wr = reg_wr && (reg_addr == RA_STAT);

  AST_CAPS_AS_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> st_caps == $past({reg_wdata[ST_CAP1], reg_wdata[ST_CAP0]})); // R8

  AST_INT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[ST_INT] && !ev_done) |=> !st_int); // R7

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_int && !(stat_wr && reg_wdata[ST_INT])) |=> st_int); // R7

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !(stat_wr && reg_wdata[ST_ERR])) |=> st_err); // R7

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (st_int && !st_active)); // R6

  AST_FAULT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (st_err && !st_active && !mem_req)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !st_active |-> (!mem_req && !dev_rd_pop && !dev_wr_push)); // R12

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_run |-> (!mem_req && !ev_done && !ev_fault)); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!cmd_run || (mem_req && $stable(mem_addr) && $stable(mem_we)))); // R13

  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_BASE) |-> (reg_rdata[1:0] == 2'b00)); // R9

  AST_ONE_FIFO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd_pop && dev_wr_push)); // R3
endmodule

bind bmdma_engine bmdma_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .mem_err     (mem_err),
  .dev_rd_pop  (dev_rd_pop),
  .dev_wr_push (dev_wr_push),
  .cmd_run     (cmd_run),
  .st_active   (st_active),
  .st_err      (st_err),
  .st_int      (st_int),
  .st_caps     (st_caps),
  .ev_done     (ev_done),
  .ev_fault    (ev_fault)
);

// File: tb/bmdma_engine_test.sv
`timescale 1ns/1ps
module bmdma_engine_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack, mem_err;
  logic [31:0] mem_rdata;
  logic        dev_rd_valid;
  logic [31:0] dev_rd_data;
  logic        dev_rd_pop;
  logic        dev_wr_ready;
  logic [31:0] dev_wr_data;
  logic        dev_wr_push;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench-side models
  logic [31:0] mem [0:1023];
  logic [31:0] push_log [0:255];
  int          pop_cnt, push_cnt, wr_cnt, lat_cnt;
  int          mem_lat;
  logic        fault_en;
  logic [31:0] fault_addr;
  logic        bd_we;
  logic [31:0] bd_addr, bd_data;
  logic        prev_req, prev_ack, prev_we;
  logic [31:0] prev_addr;
  int          hs_viol;

  bmdma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
    .dev_rd_pop(dev_rd_pop), .dev_wr_ready(dev_wr_ready),
    .dev_wr_data(dev_wr_data), .dev_wr_push(dev_wr_push), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign dev_rd_data = 32'hD000_0000 + pop_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
      lat_cnt <= 0; wr_cnt <= 0; pop_cnt <= 0; push_cnt <= 0;
    end else begin
      if (bd_we) mem[bd_addr[11:2]] <= bd_data;
      if (mem_ack) begin
        mem_ack <= 1'b0; mem_err <= 1'b0; lat_cnt <= 0;
      end else if (mem_req) begin
        if (lat_cnt >= mem_lat) begin
          mem_ack <= 1'b1; lat_cnt <= 0;
          if (fault_en && mem_addr == fault_addr) mem_err <= 1'b1;
          else begin
            mem_err   <= 1'b0;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we) begin
              mem[mem_addr[11:2]] <= mem_wdata;
              wr_cnt <= wr_cnt + 1;
            end
          end
        end else lat_cnt <= lat_cnt + 1;
      end else lat_cnt <= 0;
      if (dev_rd_pop) pop_cnt <= pop_cnt + 1;
      if (dev_wr_push) begin
        push_log[push_cnt[7:0]] <= dev_wr_data;
        push_cnt <= push_cnt + 1;
      end
    end
  end

  // handshake monitor: a pending request must keep address and kind
  always @(negedge clk) begin
    if (rst_n && prev_req && !prev_ack && mem_req &&
        (mem_addr != prev_addr || mem_we != prev_we)) hs_viol <= hs_viol + 1;
    prev_req <= mem_req; prev_ack <= mem_ack;
    prev_addr <= mem_addr; prev_we <= mem_we;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic wait_idle(input int limit, output logic [31:0] st);
    st = 32'h1;
    for (int k = 0; k < limit; k++) begin
      rd_reg(2'd1, st);
      if (!st[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic quiet_for(input int n, output int busy);
    busy = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (mem_req || dev_rd_pop || dev_wr_push) busy++;
    end
  endtask

  initial begin
    logic [31:0] rd, st;
    int          busy, runid;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dev_rd_valid = 1'b1; dev_wr_ready = 1'b1; mem_lat = 0;
    fault_en = 1'b0; fault_addr = '0; bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    hs_viol = 0; runid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, rd); check("R1 cmd after reset", rd, 32'h0);
    rd_reg(2'd1, rd); check("R1 status after reset", rd, 32'h0);
    rd_reg(2'd2, rd); check("R1 base after reset", rd, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 no request after reset", {29'b0, mem_req, dev_rd_pop, dev_wr_push}, 32'h0);

    // R9 base alignment
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, rd); check("R9 base low bits", rd, 32'hFFFF_FFFC);
    wr_reg(2'd2, 32'h0000_0123);
    rd_reg(2'd2, rd); check("R9 base low bits", rd, 32'h0000_0120);

    // R8 capability bits
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, rd); check("R8 caps all ones", rd, 32'h60);
    wr_reg(2'd1, 32'h0000_0020);
    rd_reg(2'd1, rd); check("R8 caps drive0", rd, 32'h20);
    wr_reg(2'd1, 32'h0000_0040);
    rd_reg(2'd1, rd); check("R8 caps drive1", rd, 32'h40);
    wr_reg(2'd1, 32'h0);
    rd_reg(2'd1, rd); check("R8 caps cleared", rd, 32'h0);
    wr_reg(2'd2, 32'h0);

    // sweep: direction x descriptor count x length x tail
    for (int dir = 0; dir < 2; dir++)
      for (int nd = 1; nd <= 3; nd++)
        for (int w = 1; w <= 4; w++)
          for (int tail = 0; tail < 2; tail++) begin
            int total, mism, pop0, push0, wr0, k;
            runid++;
            mem_lat = (w + tail) % 3;
            total = 0;
            for (int d = 0; d < nd; d++) begin
              int lb;
              lb = 4 * w - 3 * tail + 4 * d;
              poke(32'(8 * d), 32'h400 + 32'(d) * 32'h100);
              poke(32'(8 * d + 4), ((d == nd - 1) ? 32'h8000_0000 : 32'h0) | 32'h003C_0000 | 32'(lb));
              if (dir == 0)
                for (int i = 0; i < w + d; i++)
                  poke(32'h400 + 32'(d) * 32'h100 + 32'(4 * i), {8'hC3, 8'(runid), 8'(d), 8'(i)});
              total += w + d;
            end
            pop0 = pop_cnt; push0 = push_cnt; wr0 = wr_cnt;
            wr_reg(2'd0, (dir == 1) ? 32'h9 : 32'h1);
            rd_reg(2'd1, rd);
            check("R2 active after start", rd & 32'h1, 32'h1);
            wait_idle(2000, st);
            check("R6 status at completion", st, 32'h4);
            check("R6 irq at completion", {31'b0, irq}, 32'h1);
            mism = 0; k = 0;
            if (dir == 1) begin
              check("R5 word writes", 32'(wr_cnt - wr0), 32'(total));
              check("R3 words popped", 32'(pop_cnt - pop0), 32'(total));
              for (int d = 0; d < nd; d++)
                for (int i = 0; i < w + d; i++) begin
                  if (mem[(32'h400 + d * 32'h100) / 4 + i] !== 32'hD000_0000 + 32'(pop0 + k)) mism++;
                  k++;
                end
              check("R4 memory contents", 32'(mism), 32'h0);
            end else begin
              check("R5 words pushed", 32'(push_cnt - push0), 32'(total));
              check("R3 no memory writes", 32'(wr_cnt - wr0), 32'h0);
              for (int d = 0; d < nd; d++)
                for (int i = 0; i < w + d; i++) begin
                  if (push_log[8'(push0 + k)] !== {8'hC3, 8'(runid), 8'(d), 8'(i)}) mism++;
                  k++;
                end
              check("R4 device contents", 32'(mism), 32'h0);
            end
            if (runid == 1) begin
              // R2 a second start write while run bit is set does nothing
              wr_reg(2'd0, 32'h1);
              rd_reg(2'd1, rd); check("R2 no restart", rd, 32'h4);
              quiet_for(8, busy); check("R2 no restart activity", 32'(busy), 32'h0);
              // R7 writing zero keeps interrupt
              wr_reg(2'd1, 32'h0);
              rd_reg(2'd1, rd); check("R7 write zero keeps int", rd, 32'h4);
            end
            wr_reg(2'd1, 32'h4);
            rd_reg(2'd1, rd); check("R7 int cleared by one", rd, 32'h0);
            check("R6 irq follows int", {31'b0, irq}, 32'h0);
            wr_reg(2'd0, 32'h0);
          end
    mem_lat = 1;

    // R11 fault on data read
    poke(32'h0, 32'h400);
    poke(32'h4, 32'h8000_0010);
    fault_en = 1'b1; fault_addr = 32'h404;
    wr_reg(2'd0, 32'h1);
    wait_idle(200, st);
    check("R11 status after data fault", st, 32'h2);
    check("R11 irq after fault", {31'b0, irq}, 32'h0);
    quiet_for(8, busy); check("R11 halted after fault", 32'(busy), 32'h0);
    wr_reg(2'd1, 32'h0);
    rd_reg(2'd1, rd); check("R7 write zero keeps err", rd, 32'h2);
    wr_reg(2'd1, 32'h2);
    rd_reg(2'd1, rd); check("R7 err cleared by one", rd, 32'h0);
    wr_reg(2'd0, 32'h0);

    // R11 fault on descriptor length fetch
    fault_addr = 32'h4;
    wr_reg(2'd0, 32'h9);
    wait_idle(200, st);
    check("R11 status after table fault", st, 32'h2);
    check("R11 no memory writes after table fault", {31'b0, mem_req}, 32'h0);
    wr_reg(2'd1, 32'h2);
    wr_reg(2'd0, 32'h0);
    fault_en = 1'b0;

    // R10 abort while stalled on the device FIFO
    dev_rd_valid = 1'b0;
    wr_reg(2'd0, 32'h9);
    repeat (6) @(negedge clk);
    rd_reg(2'd1, rd); check("R10 active while stalled", rd, 32'h1);
    wr_reg(2'd0, 32'h0);
    rd_reg(2'd1, rd); check("R10 active cleared by stop", rd, 32'h0);
    dev_rd_valid = 1'b1;
    quiet_for(8, busy); check("R12 quiet after stop", 32'(busy), 32'h0);
    rd_reg(2'd1, rd); check("R10 no interrupt after stop", rd, 32'h0);

    // R5 zero count means 65536 bytes
    mem_lat = 0;
    poke(32'h0, 32'h1000);
    poke(32'h4, 32'h8000_0000);
    begin
      int wr0, pop0;
      wr0 = wr_cnt; pop0 = pop_cnt;
      wr_reg(2'd0, 32'h9);
      wait_idle(60000, st);
      check("R5 zero count status", st, 32'h4);
      check("R5 zero count word writes", 32'(wr_cnt - wr0), 32'd16384);
      check("R5 zero count words popped", 32'(pop_cnt - pop0), 32'd16384);
    end
    wr_reg(2'd1, 32'h4);
    wr_reg(2'd0, 32'h0);

    check("R13 request held until ack", 32'(hs_viol), 32'h0);

    summary();
    $finish;
  end
endmodule